// File: doc/BRIEF.md
# Octet-to-Word Cell Receiver with Minimum Length Check

This block takes a byte-wide cell stream, one octet per cycle on a fast octet clock, and turns it into 32-bit words on a word clock that runs at half that rate. The two clocks are phase-related: every second rising edge of the octet clock lines up with a rising edge of the word clock. A cell starts with the start-of-cell marker, which arrives with the cell's first octet. The rest of the cell follows in consecutive cycles. The first octet of a cell always lands in the most significant byte of the first output word. That word is presented with a start-of-cell flag.

A small write port on the word-clock side sets a minimum cell length, counted in units of four octets. A cell ends when a new start-of-cell octet arrives or when the valid input drops. At that point the receiver compares the cell's octet count with the minimum length. If the cell is too short, it sets a sticky short-cell flag, which software clears with a write-one-to-clear. A start-of-cell marker in the middle of a word restarts packing at the top byte and discards the partial word.

Top module: `octetCellRx`

## Requirements
- R1: After reset, `wordValid` is 0, `shortCellFlag` is 0 and `minCellUnits` reads 1.
- R2: Within each output word, the octets of a cell are packed big-endian: the first octet of the word is in bits 31:24, the second in 23:16, the third in 15:8 and the fourth in 7:0. Words follow the order of arrival.
- R3: Each completed group of four consecutive in-cell octets yields exactly one word. `wordValid` is high for exactly one word-clock cycle per word, and no word is lost or repeated.
- R4: `wordSoc` is 1 together with the first word of every cell and 0 for all other words; it is never 1 while `wordValid` is 0.
- R5: A write with `cfgAddr`=0 loads `cfgWrData` into the size register, which reads back on `minCellUnits` from the next word-clock cycle on. A written value of 0 is stored as 1, so the register is never 0. The minimum cell length in octets is 4 × `minCellUnits`.
- R6: A cell ends on the first cycle after its start in which `octetVld` is 0, or in which a new start-of-cell octet arrives. If it then holds fewer than 4 × `minCellUnits` octets, `shortCellFlag` becomes 1. A cell of at least that length leaves the flag unchanged.
- R7: `shortCellFlag` stays at 1 until a write with `cfgAddr`=1 and `cfgWrData` bit 0 = 1 clears it. A write with `cfgAddr`=1 and bit 0 = 0 has no effect on it. A new short cell in the same cycle as a clear wins, and the flag stays set.
- R8: A start-of-cell octet that arrives while a word is partly filled discards the partial word and places the new octet in bits 31:24 of the next word.
- R9: Octets that arrive with `octetVld`=1 but outside any cell (no start-of-cell since `octetVld` last fell) produce no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| octetClk | input | 1 | Fast octet-side clock |
| wordClk | input | 1 | Word-side clock, half the octet rate, edge-aligned |
| rstN | input | 1 | Asynchronous active-low reset for both sides |
| octetVld | input | 1 | Octet present on `octetData` this cycle |
| octetSoc | input | 1 | Start-of-cell marker, with the first octet of a cell |
| octetData | input | 8 | Incoming octet |
| cfgWrEn | input | 1 | Register write strobe (word clock) |
| cfgAddr | input | 1 | 0 = size register, 1 = flag clear |
| cfgWrData | input | 5 | Write data; bit 0 clears the flag at address 1 |
| wordValid | output | 1 | One-cycle strobe per completed word |
| wordSoc | output | 1 | Word holds the first octet of a cell |
| wordData | output | 32 | Packed word, earliest octet in the top byte |
| minCellUnits | output | 5 | Current minimum cell length in 4-octet units |
| shortCellFlag | output | 1 | Sticky short-cell violation |

## Verification
Several properties are checked on every cycle. The size register never reads zero and tracks each nonzero write. `wordValid` never stays high for two word cycles in a row. `wordSoc` never appears without a valid word. The short-cell flag never falls without a clear request. Other behaviour is shown only by the bench scenarios, which compare the output against a queue of expected words: byte order, placement of the start-of-cell flag, dropping of partial words after an early start-of-cell, dropping of stray octets, and whether a cell of a given length under a given size setting trips the flag.

// File: rtl/cellRxPkg.sv
package cellRxPkg;
  parameter int PK_LANES = 4;
  localparam int PK_LANE_W = $clog2(PK_LANES);

  // strobes from the octet-side control to the packing datapath
  typedef struct packed {
    logic                 loadFirst;  // first octet of a cell, goes to top lane
    logic                 loadNext;   // continuation octet, goes to lane
    logic [PK_LANE_W-1:0] lane;       // target lane for loadNext
    logic                 emit;       // this octet completes a word
  } packStrobe_t;
endpackage

// File: rtl/cellRxCfg.sv
module cellRxCfg
  import cellRxPkg::*;
#(
  parameter int SIZE_W  = 5,
  parameter int LIMIT_W = SIZE_W + PK_LANE_W
) (
  input  logic               wordClk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgAddr,
  input  logic [SIZE_W-1:0]  cfgWrData,
  output logic [SIZE_W-1:0]  sizeUnits,
  output logic [LIMIT_W-1:0] minOctets,
  output logic               flagClr
);
  localparam logic [SIZE_W-1:0] SIZE_ONE = SIZE_W'(1);

  logic sizeWr;
  assign sizeWr = cfgWrEn && !cfgAddr;

  always_ff @(posedge wordClk or negedge rstN) begin
    if (!rstN) begin
      sizeUnits <= SIZE_ONE;
    end else if (sizeWr) begin
      sizeUnits <= (cfgWrData == '0) ? SIZE_ONE : cfgWrData;
    end
  end

  assign minOctets = {sizeUnits, {PK_LANE_W{1'b0}}};
  assign flagClr   = cfgWrEn && cfgAddr && cfgWrData[0];
endmodule

// File: rtl/cellRxCtrl.sv
module cellRxCtrl
  import cellRxPkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int LIMIT_W = 7
) (
  input  logic               octetClk,
  input  logic               rstN,
  input  logic               octetVld,
  input  logic               octetSoc,
  input  logic [LIMIT_W-1:0] minOctets,
  input  logic               flagClr,
  output packStrobe_t        strobe,
  output logic               shortFlag
);
  localparam logic [CNT_W-1:0]     CNT_MAX  = '1;
  localparam logic [PK_LANE_W-1:0] LANE_TOP = PK_LANE_W'(PK_LANES - 1);

  logic                 inCell;
  logic [PK_LANE_W-1:0] lanePos;
  logic [CNT_W-1:0]     octCnt;
  logic                 cellEnd;
  logic                 cellShort;

  assign cellEnd   = inCell && (!octetVld || octetSoc);
  assign cellShort = cellEnd && (octCnt < CNT_W'(minOctets));

  always_comb begin
    strobe.loadFirst = octetVld && octetSoc;
    strobe.loadNext  = octetVld && !octetSoc && inCell;
    strobe.lane      = lanePos;
    strobe.emit      = strobe.loadNext && (lanePos == LANE_TOP);
  end

  always_ff @(posedge octetClk or negedge rstN) begin
    if (!rstN) begin
      inCell  <= 1'b0;
      lanePos <= '0;
      octCnt  <= '0;
    end else if (octetVld && octetSoc) begin
      inCell  <= 1'b1;
      lanePos <= PK_LANE_W'(1);
      octCnt  <= CNT_W'(1);
    end else if (octetVld && inCell) begin
      lanePos <= lanePos + 1'b1;
      if (octCnt != CNT_MAX) octCnt <= octCnt + 1'b1;
    end else if (!octetVld) begin
      inCell  <= 1'b0;
      lanePos <= '0;
    end
  end

  always_ff @(posedge octetClk or negedge rstN) begin
    if (!rstN)          shortFlag <= 1'b0;
    else if (cellShort) shortFlag <= 1'b1;
    else if (flagClr)   shortFlag <= 1'b0;
  end
endmodule

// File: rtl/cellRxPack.sv
module cellRxPack
  import cellRxPkg::*;
#(
  parameter int OCT_W  = 8,
  parameter int WORD_W = PK_LANES * OCT_W
) (
  input  logic              octetClk,
  input  logic              wordClk,
  input  logic              rstN,
  input  logic [OCT_W-1:0]  octetData,
  input  packStrobe_t       strobe,
  output logic              wordValid,
  output logic              wordSoc,
  output logic [WORD_W-1:0] wordData
);
  logic [OCT_W-1:0]  laneReg [PK_LANES-1];
  logic [WORD_W-1:0] assembled;
  logic              accSoc;
  logic [WORD_W-1:0] doneWord;
  logic              doneSoc;
  logic              doneTgl;
  logic              seenTgl;

  for (genvar g = 0; g < PK_LANES; g++) begin : gLane
    if (g == PK_LANES - 1) begin : gLast
      assign assembled[OCT_W-1:0] = octetData;
    end else begin : gHeld
      always_ff @(posedge octetClk or negedge rstN) begin
        if (!rstN) begin
          laneReg[g] <= '0;
        end else if ((strobe.loadFirst && g == 0) ||
                     (strobe.loadNext && strobe.lane == PK_LANE_W'(g))) begin
          laneReg[g] <= octetData;
        end
      end
      assign assembled[WORD_W-1-g*OCT_W -: OCT_W] = laneReg[g];
    end
  end

  // octet side: hold the finished word and flip a toggle for the word side
  always_ff @(posedge octetClk or negedge rstN) begin
    if (!rstN) begin
      accSoc   <= 1'b0;
      doneWord <= '0;
      doneSoc  <= 1'b0;
      doneTgl  <= 1'b0;
    end else begin
      if (strobe.loadFirst) begin
        accSoc <= 1'b1;
      end else if (strobe.emit) begin
        accSoc   <= 1'b0;
        doneWord <= assembled;
        doneSoc  <= accSoc;
        doneTgl  <= ~doneTgl;
      end
    end
  end

  // word side: clocks are edge-aligned, a word is held four octet cycles
  always_ff @(posedge wordClk or negedge rstN) begin
    if (!rstN) begin
      seenTgl   <= 1'b0;
      wordValid <= 1'b0;
      wordSoc   <= 1'b0;
      wordData  <= '0;
    end else begin
      seenTgl <= doneTgl;
      if (doneTgl != seenTgl) begin
        wordValid <= 1'b1;
        wordSoc   <= doneSoc;
        wordData  <= doneWord;
      end else begin
        wordValid <= 1'b0;
        wordSoc   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/octetCellRx.sv
module octetCellRx
  import cellRxPkg::*;
#(
  parameter int OCT_W  = 8,
  parameter int SIZE_W = 5,
  parameter int CNT_W  = 8
) (
  input  logic                      octetClk,
  input  logic                      wordClk,
  input  logic                      rstN,
  input  logic                      octetVld,
  input  logic                      octetSoc,
  input  logic [OCT_W-1:0]          octetData,
  input  logic                      cfgWrEn,
  input  logic                      cfgAddr,
  input  logic [SIZE_W-1:0]         cfgWrData,
  output logic                      wordValid,
  output logic                      wordSoc,
  output logic [PK_LANES*OCT_W-1:0] wordData,
  output logic [SIZE_W-1:0]         minCellUnits,
  output logic                      shortCellFlag
);
  localparam int LIMIT_W = SIZE_W + PK_LANE_W;

  logic [LIMIT_W-1:0] minOctets;
  logic               flagClr;
  packStrobe_t        strobe;

  cellRxCfg #(.SIZE_W(SIZE_W), .LIMIT_W(LIMIT_W)) uCfg (
    .wordClk  (wordClk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgWrData(cfgWrData),
    .sizeUnits(minCellUnits),
    .minOctets(minOctets),
    .flagClr  (flagClr)
  );

  cellRxCtrl #(.CNT_W(CNT_W), .LIMIT_W(LIMIT_W)) uCtrl (
    .octetClk (octetClk),
    .rstN     (rstN),
    .octetVld (octetVld),
    .octetSoc (octetSoc),
    .minOctets(minOctets),
    .flagClr  (flagClr),
    .strobe   (strobe),
    .shortFlag(shortCellFlag)
  );

  cellRxPack #(.OCT_W(OCT_W)) uPack (
    .octetClk (octetClk),
    .wordClk  (wordClk),
    .rstN     (rstN),
    .octetData(octetData),
    .strobe   (strobe),
    .wordValid(wordValid),
    .wordSoc  (wordSoc),
    .wordData (wordData)
  );
endmodule

// File: rtl/octetCellRxChk.sv
module octetCellRxChk #(
  parameter int SIZE_W = 5
) (
  input logic              octetClk,
  input logic              wordClk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic              cfgAddr,
  input logic [SIZE_W-1:0] cfgWrData,
  input logic              wordValid,
  input logic              wordSoc,
  input logic [SIZE_W-1:0] minCellUnits,
  input logic              shortCellFlag
);
  AST_SIZE_NONZERO: assert property (@(posedge wordClk) disable iff (!rstN)
    minCellUnits != '0); // R5

  AST_SIZE_WRITE: assert property (@(posedge wordClk) disable iff (!rstN)
    (cfgWrEn && !cfgAddr && cfgWrData != '0) |=> minCellUnits == $past(cfgWrData)); // R5

  AST_VALID_PULSE: assert property (@(posedge wordClk) disable iff (!rstN)
    wordValid |=> !wordValid); // R3

  AST_SOC_QUALIFIED: assert property (@(posedge wordClk) disable iff (!rstN)
    wordSoc |-> wordValid); // R4

  AST_FLAG_STICKY: assert property (@(posedge octetClk) disable iff (!rstN)
    (shortCellFlag && !(cfgWrEn && cfgAddr && cfgWrData[0])) |=> shortCellFlag); // R7
endmodule

bind octetCellRx octetCellRxChk #(.SIZE_W(SIZE_W)) uChk (.*);

// File: tb/tb_octetCellRx.sv
`timescale 1ns/100ps
module tb_octetCellRx;
  logic        octetClk = 1'b0;
  logic        wordClk  = 1'b0;
  logic        rstN     = 1'b0;
  logic        octetVld = 1'b0;
  logic        octetSoc = 1'b0;
  logic [7:0]  octetData = '0;
  logic        cfgWrEn  = 1'b0;
  logic        cfgAddr  = 1'b0;
  logic [4:0]  cfgWrData = '0;
  logic        wordValid;
  logic        wordSoc;
  logic [31:0] wordData;
  logic [4:0]  minCellUnits;
  logic        shortCellFlag;

  int total = 0;
  int bad = 0;
  logic [32:0] expQ[$];
  int  sizeNow = 1;
  bit  expFlag = 0;

  octetCellRx dut (.*);

  // 200 MHz octet clock; word clock toggles on each octet rising edge
  initial forever begin
    #2.5 octetClk = 1'b1; wordClk = ~wordClk;
    #2.5 octetClk = 1'b0;
  end

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge wordClk) begin
    if (rstN && wordValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "unexpected word", {wordSoc, wordData}, 0);
      end else begin
        logic [32:0] e;
        e = expQ.pop_front();
        check(wordData == e[31:0], "R2", "word data", wordData, e[31:0]);
        check(wordSoc == e[32], "R4", "word soc", wordSoc, e[32]);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge octetClk);
      octetVld = 1'b0; octetSoc = 1'b0;
    end
  endtask

  task automatic sendCell(int len, bit gapAfter);
    logic [31:0] w = '0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] d = 8'($urandom);
      @(negedge octetClk);
      octetVld = 1'b1; octetSoc = (i == 0); octetData = d;
      w = {w[23:0], d};
      if (i % 4 == 3) expQ.push_back({(i == 3), w});
    end
    if (len < sizeNow * 4) expFlag = 1;
    if (gapAfter) idle(1);
  endtask

  task automatic sendStray(int len);
    for (int i = 0; i < len; i++) begin
      @(negedge octetClk);
      octetVld = 1'b1; octetSoc = 1'b0; octetData = 8'($urandom);
    end
    idle(1);
  endtask

  task automatic cfgWrite(bit addr, logic [4:0] data);
    @(posedge wordClk); @(negedge octetClk);
    cfgWrEn = 1'b1; cfgAddr = addr; cfgWrData = data;
    @(posedge wordClk); @(negedge octetClk);
    cfgWrEn = 1'b0;
    if (!addr) sizeNow = (data == 0) ? 1 : int'(data);
    if (addr && data[0]) expFlag = 0;
  endtask

  task automatic checkFlag(string req);
    idle(8);
    check(shortCellFlag == expFlag, req, "short flag", shortCellFlag, expFlag);
  endtask

  initial begin
    repeat (100000) @(posedge octetClk);
    check(1'b0, "WATCHDOG", "timeout", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge octetClk);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    check(wordValid == 1'b0, "R1", "wordValid", wordValid, 0);
    check(shortCellFlag == 1'b0, "R1", "flag", shortCellFlag, 0);
    check(minCellUnits == 5'd1, "R1", "size", minCellUnits, 1);

    // R5 size writes and zero clamp
    cfgWrite(0, 5'd2);
    check(minCellUnits == 5'd2, "R5", "size write", minCellUnits, 2);
    cfgWrite(0, 5'd0);
    check(minCellUnits == 5'd1, "R5", "zero clamp", minCellUnits, 1);
    cfgWrite(0, 5'd3);
    check(minCellUnits == 5'd3, "R5", "size write", minCellUnits, 3);

    // R2 R3 R4 R6: long-enough cell, no flag
    sendCell(12, 1);
    checkFlag("R6");
    // R6: short cell ended by gap
    sendCell(8, 1);
    checkFlag("R6");
    // R7: clear with bit0=0 ignored, then real clear
    cfgWrite(1, 5'd0);
    checkFlag("R7");
    cfgWrite(1, 5'd1);
    checkFlag("R7");

    // back-to-back cells, end by new start-of-cell
    sendCell(12, 0);
    sendCell(16, 0);
    sendCell(20, 1);
    checkFlag("R6");
    sendCell(4, 0);   // short, ended by next start-of-cell
    sendCell(12, 1);
    checkFlag("R6");
    cfgWrite(1, 5'd1);

    // R8: start-of-cell mid-word drops partial word
    sendCell(6, 0);
    sendCell(12, 1);
    checkFlag("R8");
    cfgWrite(1, 5'd1);
    checkFlag("R7");

    // R9: stray octets outside a cell
    sendStray(8);
    idle(10);
    check(expQ.size() == 0, "R9", "queue drained", expQ.size(), 0);

    // random cells under random sizes
    for (int blk = 0; blk < 6; blk++) begin
      cfgWrite(0, 5'($urandom_range(0, 12)));
      for (int c = 0; c < 6; c++) begin
        sendCell($urandom_range(1, 48), (c == 5) || ($urandom_range(0, 1) == 1));
      end
      checkFlag("R6");
      cfgWrite(1, 5'd1);
      checkFlag("R7");
    end

    idle(20);
    check(expQ.size() == 0, "R3", "all words delivered", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule